// File: doc/BRIEF.md
# Downstream Hub Port Controller

This block runs the control state machine for a single downstream-facing port of a USB hub. It accepts host port requests that have already been decoded into small command codes: power on, start reset, clear enable, suspend and clear suspend. It also takes a flag saying whether the hub has been configured, a flag saying whether the whole hub is suspended, and an abstracted view of the line: a connect level, an activity level, an end-of-frame (EOF2) strobe and a resume strobe from the device.

From these inputs it drives four things. It drives SE0 onto the port while the hub is unconfigured and while a port reset is in progress. It reports the power, enable and suspend status and a state code. It arms babble detection only while the port is enabled. It holds a sticky change flag that the status-change endpoint reads and the host acknowledges.

A babble or a disconnect affects this port alone. A resume from a suspended port stays local unless the hub itself is suspended, in which case a one-cycle forward request goes upstream. One instance is placed per downstream port.

Top module: `hub_dnport_ctrl`

## Requirements
- R1: While `hub_cfg_i` is low, the next cycle shows state code 0 (unconfigured) with `se0_o`=1 and `port_pwr_o`=0, whatever the other inputs are. This is also the state after reset.
- R2: When configured, the port moves from code 0 to code 1 (configured, unpowered), where SE0 is released and power stays off. Only command code 1 (power on) moves it on, to code 2 (disconnected, powered).
- R3: In any powered state (codes 2 to 6), a low `line_conn_i` returns the port to code 2 in the next cycle. In code 2, a high `line_conn_i` moves it to code 3 (disabled, connected).
- R4: Command code 2 (reset), taken in code 3 or code 5, enters code 4 (resetting). Code 4 drives `se0_o` for exactly RST_CYCLES cycles and then enters code 5 (enabled) with `babble_arm_o`=1.
- R5: While the port is in code 5, babble sends it to code 3 in the next cycle. Babble is either `line_act_i` high for BABBLE_CYCLES consecutive cycles, or `line_act_i` high when `eof2_i` strobes.
- R6: Command code 3 (clear enable), taken in code 5 or code 6, moves the port to code 3.
- R7: Command code 4 (suspend), taken in code 5, enters code 6 with `port_susp_o`=1 and `port_en_o`=1. Command code 5 (clear suspend), taken in code 6, returns to code 5.
- R8: `resume_i` in code 6 returns the port to code 5. In that same cycle `resume_up_o` pulses for one cycle, but only if `hub_susp_i` was high when the resume was taken.
- R9: `chg_o` rises one cycle after any change of state code and stays high until a cycle with `chg_ack_i` high and no new state change.
- R10: Priority from highest to lowest is: unconfigured, then disconnect, then babble, then host command. Command codes 0, 6 and 7, and any command not listed for the current state, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hub_cfg_i | input | 1 | Hub has been configured by the host |
| hub_susp_i | input | 1 | Whole hub is suspended |
| cmd_valid_i | input | 1 | Host port command strobe |
| cmd_i | input | 3 | Command code: 1 power, 2 reset, 3 clear enable, 4 suspend, 5 clear suspend |
| line_conn_i | input | 1 | Device connected on the port |
| line_act_i | input | 1 | Line is non-idle (device traffic) |
| eof2_i | input | 1 | Strobe at the EOF2 point of the frame |
| resume_i | input | 1 | Resume signalling seen from the device |
| chg_ack_i | input | 1 | Host acknowledge of the change flag |
| state_o | output | 3 | Port state code (0 to 6, see requirements) |
| se0_o | output | 1 | Drive SE0 on the port lines |
| port_pwr_o | output | 1 | Port power switch enable |
| port_en_o | output | 1 | Port enabled status |
| port_susp_o | output | 1 | Port suspended status |
| babble_arm_o | output | 1 | Babble detection armed |
| chg_o | output | 1 | Sticky port change indication |
| resume_up_o | output | 1 | One-cycle request to forward a resume upstream |

## Verification
The bench checks the length of the reset SE0 window. A timer that is off by one would show an SE0 run of RST_CYCLES plus or minus one.

It forces babble exactly at the activity-length limit and at an EOF2 strobe. A counter that fires a cycle late would leave the port enabled a cycle too long.

It drives a resume with the hub suspended and again with it awake. A broken gate would forward local resumes upstream, or drop the upstream request.

It collides commands with disconnects and with loss of configuration, and it lands a change on the same cycle as an acknowledge. A wrong priority order shows up as a state code that differs from the expected one.

// File: rtl/hub_port_pkg.sv
// Package: shared state codes and command codes for the downstream port
// controller. Assumes a 3-bit command field decoded upstream of the block.
package hub_port_pkg;

    typedef enum logic [2:0] {
        ST_UNCFG = 3'd0,   // hub not configured, SE0 driven, unpowered
        ST_OFF   = 3'd1,   // configured, unpowered, lines released
        ST_DISC  = 3'd2,   // powered, no device
        ST_DIS   = 3'd3,   // device present, port disabled
        ST_RST   = 3'd4,   // port reset, SE0 driven
        ST_EN    = 3'd5,   // port enabled
        ST_SUSP  = 3'd6    // port suspended
    } port_st_e;

    localparam logic [2:0] CMD_POWER = 3'd1;
    localparam logic [2:0] CMD_RESET = 3'd2;
    localparam logic [2:0] CMD_CLREN = 3'd3;
    localparam logic [2:0] CMD_SUSP  = 3'd4;
    localparam logic [2:0] CMD_CLRSU = 3'd5;

endpackage

// File: rtl/hub_port_rst_timer.sv
// Module: times the port-reset SE0 window.
// done_o is high in the last of RST_CYCLES consecutive cycles with run_i high.
// Assumes run_i stays high for the whole window and drops right after it.
module hub_port_rst_timer #(
    parameter int RST_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent in reset; clear whenever the window is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/hub_port_babble.sv
// Module: babble detector for one enabled port.
// Flags babble when the line has been active for LIMIT consecutive cycles
// (unterminated traffic) or when it is active at the EOF2 strobe.
// Assumes arm_i is high only while the port is enabled.
module hub_port_babble #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic line_act_i,
    input  logic eof2_i,
    output logic babble_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] run_q;

    // Length of the current run of line activity while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i || !line_act_i) run_q <= '0;
        else if (run_q != LAST) run_q <= run_q + 1'b1;
    end

    assign babble_o = arm_i && line_act_i && (eof2_i || (run_q == LAST));
endmodule

// File: rtl/hub_port_chg.sv
// Module: sticky change indication for the status-change endpoint.
// Sets one cycle after any change of the state code, and clears on an
// acknowledge. A new change wins over an acknowledge in the same cycle.
module hub_port_chg
    import hub_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  port_st_e state_i,
    input  logic     ack_i,
    output logic     chg_o
);
    port_st_e prev_q;
    logic     chg_q;

    // Keep a delayed copy of the state to spot transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= ST_UNCFG;
        else        prev_q <= state_i;
    end

    // Sticky flag: set on a transition, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 chg_q <= 1'b0;
        else if (state_i != prev_q) chg_q <= 1'b1;
        else if (ack_i)             chg_q <= 1'b0;
    end

    assign chg_o = chg_q;
endmodule

// File: rtl/hub_port_fsm.sv
// Module: next-state logic and state register of the port.
// Priority: loss of configuration, then disconnect, then babble, then the
// host command. Also produces the one-cycle upstream resume request.
module hub_port_fsm
    import hub_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hub_cfg_i,
    input  logic       hub_susp_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_i,
    input  logic       line_conn_i,
    input  logic       resume_i,
    input  logic       babble_i,
    input  logic       rst_done_i,
    output port_st_e   state_o,
    output logic       resume_up_o
);
    port_st_e st_q, st_d;
    logic     up_q, up_d;
    logic     c_pwr, c_rst, c_clren, c_susp, c_clrsu;

    // Decode the host command strobe.
    always_comb begin
        c_pwr   = cmd_valid_i && (cmd_i == CMD_POWER);
        c_rst   = cmd_valid_i && (cmd_i == CMD_RESET);
        c_clren = cmd_valid_i && (cmd_i == CMD_CLREN);
        c_susp  = cmd_valid_i && (cmd_i == CMD_SUSP);
        c_clrsu = cmd_valid_i && (cmd_i == CMD_CLRSU);
    end

    // Next-state selection with fixed priority.
    always_comb begin
        st_d = st_q;
        up_d = 1'b0;
        if (!hub_cfg_i) begin
            st_d = ST_UNCFG;
        end else begin
            case (st_q)
                ST_UNCFG: st_d = ST_OFF;
                ST_OFF:   if (c_pwr) st_d = ST_DISC;
                default: begin
                    if (!line_conn_i) begin
                        st_d = ST_DISC;
                    end else begin
                        case (st_q)
                            ST_DISC: st_d = ST_DIS;
                            ST_DIS:  if (c_rst) st_d = ST_RST;
                            ST_RST:  if (rst_done_i) st_d = ST_EN;
                            ST_EN: begin
                                if (babble_i)     st_d = ST_DIS;
                                else if (c_rst)   st_d = ST_RST;
                                else if (c_clren) st_d = ST_DIS;
                                else if (c_susp)  st_d = ST_SUSP;
                            end
                            ST_SUSP: begin
                                if (c_clren)       st_d = ST_DIS;
                                else if (c_clrsu)  st_d = ST_EN;
                                else if (resume_i) begin
                                    st_d = ST_EN;
                                    up_d = hub_susp_i;
                                end
                            end
                            default: st_d = ST_UNCFG;
                        endcase
                    end
                end
            endcase
        end
    end

    // State and resume-request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_UNCFG;
            up_q <= 1'b0;
        end else begin
            st_q <= st_d;
            up_q <= up_d;
        end
    end

    assign state_o     = st_q;
    assign resume_up_o = up_q;
endmodule

// File: rtl/hub_dnport_ctrl.sv
// Module: top of one downstream hub port controller.
// Wires the state machine to the reset timer, the babble detector and the
// change tracker, and decodes the status outputs from the state code.
// RST_CYCLES defaults to 10 ms at a 200 MHz system clock.
module hub_dnport_ctrl
    import hub_port_pkg::*;
#(
    parameter int RST_CYCLES    = 2_000_000,
    parameter int BABBLE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hub_cfg_i,
    input  logic       hub_susp_i,
    input  logic       cmd_valid_i,
    input  logic [2:0] cmd_i,
    input  logic       line_conn_i,
    input  logic       line_act_i,
    input  logic       eof2_i,
    input  logic       resume_i,
    input  logic       chg_ack_i,
    output logic [2:0] state_o,
    output logic       se0_o,
    output logic       port_pwr_o,
    output logic       port_en_o,
    output logic       port_susp_o,
    output logic       babble_arm_o,
    output logic       chg_o,
    output logic       resume_up_o
);
    port_st_e st;
    logic     armed, babble, rst_done, in_rst;

    assign in_rst = (st == ST_RST);
    assign armed  = (st == ST_EN);

    hub_port_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .run_i(in_rst), .done_o(rst_done)
    );

    hub_port_babble #(.LIMIT(BABBLE_CYCLES)) u_bab (
        .clk(clk), .rst_n(rst_n), .arm_i(armed), .line_act_i(line_act_i),
        .eof2_i(eof2_i), .babble_o(babble)
    );

    hub_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hub_cfg_i(hub_cfg_i), .hub_susp_i(hub_susp_i),
        .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .line_conn_i(line_conn_i),
        .resume_i(resume_i), .babble_i(babble), .rst_done_i(rst_done),
        .state_o(st), .resume_up_o(resume_up_o)
    );

    hub_port_chg u_chg (
        .clk(clk), .rst_n(rst_n), .state_i(st), .ack_i(chg_ack_i), .chg_o(chg_o)
    );

    // Status decode from the state code.
    always_comb begin
        state_o      = st;
        se0_o        = (st == ST_UNCFG) || (st == ST_RST);
        port_pwr_o   = (st != ST_UNCFG) && (st != ST_OFF);
        port_en_o    = (st == ST_EN) || (st == ST_SUSP);
        port_susp_o  = (st == ST_SUSP);
        babble_arm_o = armed;
    end
endmodule

// File: rtl/hub_dnport_ctrl_chk.sv
// Checker: temporal properties of the port controller, bound to the top.
module hub_dnport_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hub_cfg_i,
    input logic       hub_susp_i,
    input logic       line_conn_i,
    input logic       line_act_i,
    input logic       eof2_i,
    input logic       chg_ack_i,
    input logic [2:0] state_o,
    input logic       se0_o,
    input logic       port_pwr_o,
    input logic       port_en_o,
    input logic       port_susp_o,
    input logic       babble_arm_o,
    input logic       chg_o,
    input logic       resume_up_o
);
    a_r1_unconfig_se0: assert property (@(posedge clk) disable iff (!rst_n)
        !hub_cfg_i |=> (se0_o && !port_pwr_o && state_o == 3'd0));

    a_r3_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_cfg_i && port_pwr_o && !line_conn_i) |=> (state_o == 3'd2 && !se0_o));

    a_r4_no_arm_in_se0: assert property (@(posedge clk) disable iff (!rst_n)
        (se0_o && port_pwr_o) |-> !babble_arm_o);

    a_r5_eof2_babble: assert property (@(posedge clk) disable iff (!rst_n)
        (babble_arm_o && eof2_i && line_act_i) |=> !port_en_o);

    a_r7_susp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        port_susp_o |-> port_en_o);

    a_r8_resume_gate: assert property (@(posedge clk) disable iff (!rst_n)
        resume_up_o |-> ($past(hub_susp_i) && port_en_o && !port_susp_o));

    a_r9_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_o && !chg_ack_i) |=> chg_o);
endmodule

bind hub_dnport_ctrl hub_dnport_ctrl_chk u_chk (.*);

// File: tb/tb_hub_dnport_ctrl.sv
module tb_hub_dnport_ctrl;
    localparam int RSTC = 16;
    localparam int BABC = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hub_cfg_i = 0, hub_susp_i = 0, cmd_valid_i = 0, line_conn_i = 0;
    logic line_act_i = 0, eof2_i = 0, resume_i = 0, chg_ack_i = 0;
    logic [2:0] cmd_i = 0;
    logic [2:0] state_o;
    logic se0_o, port_pwr_o, port_en_o, port_susp_o, babble_arm_o, chg_o, resume_up_o;

    int checks = 0, fails = 0, wd = 0;

    // Reference model state
    logic [2:0] m_st = 0, m_prev = 0;
    int m_rc = 0, m_bc = 0;
    logic m_chg = 0, m_up = 0;

    always #2.5 clk = ~clk;

    hub_dnport_ctrl #(.RST_CYCLES(RSTC), .BABBLE_CYCLES(BABC)) dut (.*);

    // Model next state from the requirements (R1..R10 priority order).
    function automatic logic [2:0] f_next(input logic [2:0] s, input logic bab, input logic done);
        logic [2:0] n = s;
        logic cv = cmd_valid_i;
        if (!hub_cfg_i) return 3'd0;
        if (s == 0) return 3'd1;
        if (s == 1) return (cv && cmd_i == 1) ? 3'd2 : 3'd1;
        if (!line_conn_i) return 3'd2;
        case (s)
            2: n = 3;
            3: if (cv && cmd_i == 2) n = 4;
            4: if (done) n = 5;
            5: if (bab) n = 3;
               else if (cv && cmd_i == 2) n = 4;
               else if (cv && cmd_i == 3) n = 3;
               else if (cv && cmd_i == 4) n = 6;
            6: if (cv && cmd_i == 3) n = 3;
               else if (cv && cmd_i == 5) n = 5;
               else if (resume_i) n = 5;
            default: n = 0;
        endcase
        return n;
    endfunction

    // Advance the model on each clock edge with the same inputs as the DUT.
    always @(posedge clk) begin
        logic bab, done, up;
        logic [2:0] n;
        if (!rst_n) begin
            m_st <= 0; m_prev <= 0; m_rc <= 0; m_bc <= 0; m_chg <= 0; m_up <= 0;
        end else begin
            bab  = (m_st == 5) && line_act_i && (eof2_i || m_bc == BABC - 1);
            done = (m_st == 4) && (m_rc == RSTC - 1);
            n = f_next(m_st, bab, done);
            up = hub_cfg_i && line_conn_i && m_st == 6 && n == 5 && resume_i && hub_susp_i
                 && !(cmd_valid_i && (cmd_i == 3 || cmd_i == 5));
            m_up <= up;
            m_rc <= (m_st == 4) ? m_rc + 1 : 0;
            m_bc <= (m_st == 5 && line_act_i) ? m_bc + 1 : 0;
            m_prev <= m_st;
            if (m_st != m_prev) m_chg <= 1'b1;
            else if (chg_ack_i) m_chg <= 1'b0;
            m_st <= n;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every output to the model.
    task automatic cmp_all();
        chk("R10 state", state_o, m_st);
        chk("R1 se0", se0_o, (m_st == 0 || m_st == 4));
        chk("R2 pwr", port_pwr_o, (m_st >= 2));
        chk("R6 en", port_en_o, (m_st == 5 || m_st == 6));
        chk("R7 susp", port_susp_o, (m_st == 6));
        chk("R5 arm", babble_arm_o, (m_st == 5));
        chk("R9 chg", chg_o, m_chg);
        chk("R8 resume_up", resume_up_o, m_up);
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
        wd++;
        cmp_all();
        cmd_valid_i = 0; eof2_i = 0; resume_i = 0; chg_ack_i = 0;
    endtask

    task automatic cmd(input logic [2:0] c);
        cmd_valid_i = 1; cmd_i = c; tick();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expected=finish actual=hang");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        // R1: reset state
        chk("R1 reset state", state_o, 0);
        chk("R1 reset se0", se0_o, 1);
        // R2: configure, ignored commands in OFF
        hub_cfg_i = 1; tick();
        chk("R2 off", state_o, 1);
        cmd(3'd2); chk("R2 cmd ignored", state_o, 1);
        line_conn_i = 1; cmd(3'd1); chk("R2 power", state_o, 2);
        tick(); chk("R3 connect", state_o, 3);
        // R4: reset window length
        cmd(3'd2); n = 0;
        while (se0_o && n < 100) begin n++; tick(); end
        chk("R4 se0 cycles", n, RSTC);
        chk("R4 enabled", state_o, 5);
        // R5: long activity babble
        line_act_i = 1;
        repeat (BABC) tick();
        chk("R5 run babble", state_o, 3);
        line_act_i = 0; tick();
        // R7/R8: suspend then local resume
        cmd(3'd2); repeat (RSTC) tick();
        cmd(3'd4); chk("R7 suspended", state_o, 6);
        hub_susp_i = 0; resume_i = 1; tick();
        chk("R8 local resume", {resume_up_o, state_o}, {1'b0, 3'd5});
        cmd(3'd4); hub_susp_i = 1; resume_i = 1; tick();
        chk("R8 forwarded resume", {resume_up_o, state_o}, {1'b1, 3'd5});
        hub_susp_i = 0;
        // R10: disconnect beats command; R6 clear enable
        cmd(3'd3); chk("R6 clear enable", state_o, 3);
        line_conn_i = 0; cmd(3'd2); chk("R10 disconnect wins", state_o, 2);
        line_conn_i = 1; tick();
        // R9: ack with no change clears
        chg_ack_i = 1; tick(); chg_ack_i = 1; tick();
        chk("R9 ack clears", chg_o, 0);
        // Random phase
        for (int i = 0; i < 6000; i++) begin
            hub_cfg_i   = ($urandom_range(0, 99) > 1);
            line_conn_i = ($urandom_range(0, 99) > 3);
            hub_susp_i  = $urandom_range(0, 1);
            line_act_i  = ($urandom_range(0, 99) < 25);
            eof2_i      = ($urandom_range(0, 99) < 5);
            resume_i    = ($urandom_range(0, 99) < 8);
            chg_ack_i   = ($urandom_range(0, 99) < 20);
            cmd_valid_i = ($urandom_range(0, 99) < 30);
            cmd_i       = 3'($urandom_range(0, 7));
            @(posedge clk); @(negedge clk);
            wd++;
            cmp_all();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule